// File: doc/BRIEF.md
# Ripple Add/Subtract Unit with Signed Compare Flags

This block is a purely combinational two's complement arithmetic unit of parameterizable width. A single mode pin chooses between addition and subtraction of two operands. Both operations share one chain of full adders: in subtract mode every bit of the second operand is inverted, and a one is injected as the carry into the least significant stage. This forms A plus the two's complement of B.

The block also reports several status flags taken from that same chain. These are the raw carry out, a signed overflow flag, the result sign and a zero detect. In subtract mode it adds three signed compare outputs: less-than, equal and less-or-equal. The less-than output stays correct when the difference overflows, so a caller can compare any two signed operands with one subtraction. The data pins have no handshake. The outputs follow the inputs after the adder's propagation delay, and any register staging belongs to the surrounding logic.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With `sub_i` = 0, `res_o` equals (A + B) mod 2^WIDTH, and `cout_o` is 1 exactly when the unsigned sum reaches 2^WIDTH.
- R2: With `sub_i` = 1, `res_o` equals (A - B) mod 2^WIDTH, and `cout_o` is 1 exactly when A >= B taken as unsigned numbers (not-borrow).
- R3: `ovf_o` is 1 exactly when the true signed result of the selected operation lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. For example, at 4 bits both 5 + 3 and -7 - 2 set it.
- R4: `neg_o` equals bit WIDTH-1 of `res_o` in both modes.
- R5: `zero_o` is 1 exactly when every bit of `res_o` is 0, in both modes.
- R6: With `sub_i` = 1, `lt_o` is 1 exactly when A < B as signed numbers, including pairs whose difference overflows.
- R7: With `sub_i` = 1, `eq_o` is 1 exactly when A equals B, and it then matches `zero_o`.
- R8: With `sub_i` = 1, `le_o` is 1 exactly when A <= B as signed numbers, that is, `lt_o` OR `zero_o`.
- R9: With `sub_i` = 0, `lt_o`, `eq_o` and `le_o` are all 0 for any operands.
- R10: The parameter WIDTH (at least 2) sets every operand and result width, and R1 to R9 hold unchanged at a width other than 4 (checked at 6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand A, two's complement |
| opb_i | input | WIDTH | Second operand B, two's complement |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| res_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry out of the top stage |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Result sign bit |
| zero_o | output | 1 | Result is all zeros |
| lt_o | output | 1 | A < B signed (subtract mode only) |
| eq_o | output | 1 | A == B (subtract mode only) |
| le_o | output | 1 | A <= B signed (subtract mode only) |

## Verification
At 4 bits the bench drives every operand pair in both modes. This covers the two overflow directions, the most-negative operand, and equal operands. It also separates a less-than derived from the sign alone from one corrected by overflow, because those two differ only on overflowing differences. A second instance at 6 bits receives seeded random operands plus directed extremes (max, min, zero, minus one). Any bit-index or width slip that 4 bits would hide shows up there. In add mode the compare outputs are checked against zero on the same vectors that make them true in subtract mode, so a missing mode gate is caught.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } op_mode_e;

  // Minimum supported operand width
  localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/as_full_adder.sv
module as_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = a_i ^ b_i ^ c_i;
    c_o = (a_i & b_i) | (c_i & (a_i | b_i));
  end
endmodule

// File: rtl/as_operand_cond.sv
module as_operand_cond #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] opb_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] opb_eff_o,
  output logic             cin_o
);
  import addsub_pkg::*;

  op_mode_e mode;
  assign mode = op_mode_e'(sub_i);

  // One 2:1 selector per bit: true or inverted operand
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign opb_eff_o[i] = (mode == MODE_SUB) ? ~opb_i[i] : opb_i[i];
  end

  // The +1 of the two's complement enters as the chain carry-in
  assign cin_o = (mode == MODE_SUB);
endmodule

// File: rtl/as_ripple_chain.sv
module as_ripple_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_into_msb_o,
  output logic             c_out_o
);
  logic carry [0:WIDTH];

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    as_full_adder u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign c_into_msb_o = carry[WIDTH-1];
  assign c_out_o      = carry[WIDTH];
endmodule

// File: rtl/as_flag_unit.sv
module as_flag_unit #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             c_into_msb_i,
  input  logic             c_out_i,
  input  logic             sub_i,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic             le_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic lt_raw;

  always_comb begin
    // Overflow when the sign stage's carry in and carry out disagree
    ovf_o  = c_into_msb_i ^ c_out_i;
    neg_o  = sum_i[MSB];
    zero_o = ~|sum_i;
    // Sign of the difference, corrected when the difference overflowed
    lt_raw = neg_o ^ ovf_o;
    // Compare outputs are meaningful only for a subtraction
    lt_o   = sub_i & lt_raw;
    eq_o   = sub_i & zero_o;
    le_o   = sub_i & (lt_raw | zero_o);
  end
endmodule

// File: rtl/addsub_cmp_unit.sv
module addsub_cmp_unit #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic             le_o
);
  logic [WIDTH-1:0] opb_eff;
  logic             chain_cin;
  logic             c_into_msb;

  as_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .opb_i     (opb_i),
    .sub_i     (sub_i),
    .opb_eff_o (opb_eff),
    .cin_o     (chain_cin)
  );

  as_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i          (opa_i),
    .b_i          (opb_eff),
    .cin_i        (chain_cin),
    .sum_o        (res_o),
    .c_into_msb_o (c_into_msb),
    .c_out_o      (cout_o)
  );

  as_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .sum_i        (res_o),
    .c_into_msb_i (c_into_msb),
    .c_out_i      (cout_o),
    .sub_i        (sub_i),
    .ovf_o        (ovf_o),
    .neg_o        (neg_o),
    .zero_o       (zero_o),
    .lt_o         (lt_o),
    .eq_o         (eq_o),
    .le_o         (le_o)
  );
endmodule

// File: rtl/addsub_cmp_checker.sv
module addsub_cmp_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             cout_o,
  input logic             ovf_o,
  input logic             neg_o,
  input logic             zero_o,
  input logic             lt_o,
  input logic             eq_o,
  input logic             le_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_seen;
  logic             same_sign_in;
  logic             sign_flip;

  always_comb begin
    b_seen       = sub_i ? ~opb_i : opb_i;
    same_sign_in = ~(opa_i[MSB] ^ b_seen[MSB]);
    sign_flip    = res_o[MSB] ^ opa_i[MSB];

    AST_NEG_IS_MSB:   assert (neg_o == res_o[MSB]);                   // R4
    AST_ZERO_DETECT:  assert (zero_o == (res_o == '0));               // R5
    AST_OVF_BY_SIGNS: assert (ovf_o == (same_sign_in & sign_flip));   // R3
    AST_ADD_NO_CMP:   assert (sub_i || !(lt_o || eq_o || le_o));      // R9
    AST_EQ_OPERANDS:  assert (!sub_i || (eq_o == (opa_i == opb_i)));  // R7
    AST_LE_IS_LT_OR_Z: assert (!sub_i || (le_o == (lt_o | zero_o))); // R8
    AST_NOT_BORROW:   assert (!sub_i || (cout_o == (opa_i >= opb_i))); // R2
  end
endmodule

bind addsub_cmp_unit addsub_cmp_checker #(.WIDTH(WIDTH)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .sub_i  (sub_i),
  .res_o  (res_o),
  .cout_o (cout_o),
  .ovf_o  (ovf_o),
  .neg_o  (neg_o),
  .zero_o (zero_o),
  .lt_o   (lt_o),
  .eq_o   (eq_o),
  .le_o   (le_o)
);

// File: tb/addsub_cmp_unit_tb.sv
`timescale 1ns/1ps
module addsub_cmp_unit_tb;
  localparam int W4 = 4;
  localparam int W6 = 6;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [W4-1:0] a4, b4, r4;
  logic          s4, co4, ov4, ng4, z4, lt4, eq4, le4;
  logic [W6-1:0] a6, b6, r6;
  logic          s6, co6, ov6, ng6, z6, lt6, eq6, le6;

  addsub_cmp_unit #(.WIDTH(W4)) u_dut (
    .opa_i(a4), .opb_i(b4), .sub_i(s4), .res_o(r4), .cout_o(co4),
    .ovf_o(ov4), .neg_o(ng4), .zero_o(z4), .lt_o(lt4), .eq_o(eq4), .le_o(le4)
  );

  addsub_cmp_unit #(.WIDTH(W6)) u_dut_w6 (
    .opa_i(a6), .opb_i(b6), .sub_i(s6), .res_o(r6), .cout_o(co6),
    .ovf_o(ov6), .neg_o(ng6), .zero_o(z6), .lt_o(lt6), .eq_o(eq6), .le_o(le6)
  );

  typedef struct {
    int res; int cout; int ovf; int neg; int zero; int lt; int eq; int le;
  } exp_t;

  function automatic exp_t model(int w, int a, int b, int sub);
    exp_t e;
    int mask = (1 << w) - 1;
    int half = 1 << (w - 1);
    int sa = (a >= half) ? a - (1 << w) : a;
    int sb = (b >= half) ? b - (1 << w) : b;
    int raw = sub ? a + ((~b) & mask) + 1 : a + b;
    int tru = sub ? sa - sb : sa + sb;
    e.res  = raw & mask;
    e.cout = (raw >> w) & 1;
    e.ovf  = (tru < -half || tru > half - 1) ? 1 : 0;
    e.neg  = (e.res >> (w - 1)) & 1;
    e.zero = (e.res == 0) ? 1 : 0;
    e.lt   = (sub != 0 && sa < sb) ? 1 : 0;
    e.eq   = (sub != 0 && a == b) ? 1 : 0;
    e.le   = (sub != 0 && sa <= sb) ? 1 : 0;
    return e;
  endfunction

  task automatic chk(string req, string what, int act, int exp, int a, int b, int sub);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
               req, what, a, b, sub, act, exp);
    end
  endtask

  task automatic check_all(string wreq, exp_t e, int a, int b, int sub,
                           int res, int co, int ov, int ng, int z, int lt, int eq, int le);
    chk(sub ? {wreq, "R2"} : {wreq, "R1"}, "res", res, e.res, a, b, sub);
    chk(sub ? {wreq, "R2"} : {wreq, "R1"}, "cout", co, e.cout, a, b, sub);
    chk({wreq, "R3"}, "ovf", ov, e.ovf, a, b, sub);
    chk({wreq, "R4"}, "neg", ng, e.neg, a, b, sub);
    chk({wreq, "R5"}, "zero", z, e.zero, a, b, sub);
    chk(sub ? {wreq, "R6"} : {wreq, "R9"}, "lt", lt, e.lt, a, b, sub);
    chk(sub ? {wreq, "R7"} : {wreq, "R9"}, "eq", eq, e.eq, a, b, sub);
    chk(sub ? {wreq, "R8"} : {wreq, "R9"}, "le", le, e.le, a, b, sub);
  endtask

  task automatic apply4(int a, int b, int sub);
    @(posedge clk);
    a4 = W4'(a); b4 = W4'(b); s4 = sub[0];
    @(negedge clk);
    check_all("", model(W4, a, b, sub), a, b, sub, int'(r4), int'(co4), int'(ov4),
              int'(ng4), int'(z4), int'(lt4), int'(eq4), int'(le4));
  endtask

  task automatic apply6(int a, int b, int sub);
    @(posedge clk);
    a6 = W6'(a); b6 = W6'(b); s6 = sub[0];
    @(negedge clk);
    check_all("R10/", model(W6, a, b, sub), a, b, sub, int'(r6), int'(co6), int'(ov6),
              int'(ng6), int'(z6), int'(lt6), int'(eq6), int'(le6));
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    int seed_dummy;
    a4 = '0; b4 = '0; s4 = 1'b0;
    a6 = '0; b6 = '0; s6 = 1'b0;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: zero operands in add mode give zero result, zero flag set (R1, R5)
    check_all("", model(W4, 0, 0, 0), 0, 0, 0, int'(r4), int'(co4), int'(ov4),
              int'(ng4), int'(z4), int'(lt4), int'(eq4), int'(le4));

    // Directed overflow cases: 5+3 and -7-2 must overflow (R3)
    apply4(5, 3, 0);
    chk("R3", "ovf 5+3", int'(ov4), 1, 5, 3, 0);
    apply4(9, 2, 1);
    chk("R3", "ovf -7-2", int'(ov4), 1, 9, 2, 1);
    // Overflowing difference must still compare correctly: -8 < 7 (R6)
    apply4(8, 7, 1);
    chk("R6", "lt -8<7", int'(lt4), 1, 8, 7, 1);
    // Add mode with equal operands keeps compares low (R9)
    apply4(6, 6, 0);
    chk("R9", "eq in add", int'(eq4), 0, 6, 6, 0);

    // Exhaustive at 4 bits, both modes (R1..R9)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply4(a, b, m);

    // Width 6: directed extremes then seeded random (R10)
    begin
      int corner [6] = '{0, 1, 31, 32, 33, 63};
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int m = 0; m < 2; m++)
            apply6(corner[i], corner[j], m);
    end
    for (int k = 0; k < 400; k++)
      apply6(int'($urandom_range(63)), int'($urandom_range(63)), int'($urandom_range(1)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule